// File: doc/BRIEF.md
# 32-Pin GPIO Port Register Block

This block is the register front end for one 32-pin general-purpose I/O port. It keeps a 32-bit output data register, split into a high half (bits 31..16) and a low half (bits 15..0). It also presents a read-only view of the pin levels, split the same way. A simple synchronous bus reaches all of it with byte, halfword or word accesses. A per-pin direction vector comes from elsewhere in the chip. That vector decides whether a pin is driven from the data register, and whether a data read returns the stored bit or the sampled pin.

Pin inputs pass through a two-stage synchronizer before any read path sees them. The data register is cleared only by the power-on/deep-standby reset. The manual reset clears only the read-data output and leaves the stored data alone. Read data appears on `bus_rdata` one cycle after the request and is zero in every other cycle.

Address map (byte offsets on `bus_addr`): 0 is the data high half, 2 is the data low half, 4 is the pin-state high half and 6 is the pin-state low half. `bus_size` encodes 0 as byte, 1 as halfword, 2 as word and 3 as reserved. Byte data uses lanes 7..0, halfword data uses lanes 15..0, and word data uses lanes 31..0.

Top module: `gpio32_port`

## Requirements
- R1: While `por_rst` is high at a clock edge, the data register clears to zero. From the next cycle `pin_out` and `bus_rdata` are zero.
- R2: `man_rst` leaves the data register (and so `pin_out`) unchanged. It forces `bus_rdata` to zero in the following cycle.
- R3: A word access at offset 0 covers both data halves, with the high half in `bus_rdata[31:16]`. A word access at offset 4 covers both pin-state halves in the same arrangement.
- R4: A halfword access at offset 0 reaches data bits 31..16 and one at offset 2 reaches bits 15..0, each on lanes 15..0.
- R5: Byte accesses are big-endian. Offsets 0, 1, 2 and 3 reach data bits 31..24, 23..16, 15..8 and 7..0, and a byte write changes only the addressed byte.
- R6: Certain accesses are illegal: a word at offset 2 or 6, a halfword at an odd offset, and any access of size 3. Such a write changes nothing, and such a read returns zero. `bus_rdata` is zero after any cycle without a read.
- R7: `pin_oe` equals `pin_dir` (1 = output). An output pin drives its stored data bit, and an input pin drives 0.
- R8: A data-register read returns the stored bit for output pins and the synchronized pin level for input pins.
- R9: A write to a data bit whose pin is an input is stored without changing `pin_out`. The stored value drives the pin once the pin turns to output.
- R10: Pin-state reads return the synchronized pin levels whatever the direction. Writes to offsets 4 and 6 change nothing.
- R11: Two register stages sit between `pin_in` and every read path. A read accepted on the first or second edge after a pin change returns the old level, and one accepted on the third edge returns the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous power-on / deep-standby reset, active high |
| man_rst | input | 1 | Synchronous manual reset, active high |
| bus_req | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset within the block |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| pin_dir | input | 32 | Per-pin direction, 1 = output |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Pin drive values |
| pin_oe | output | 32 | Pin output enables |

## Verification
The checks assume two things about the inputs: `por_rst` is high from time zero until the first properties are evaluated, and `pin_dir` is only compared across a cycle when the properties on stable `pin_out` qualify on it. The properties that require `pin_out` to hold also assume no write in the same cycle. The bench changes `pin_dir` only between accesses, never during a manual reset or a write to the pin-state offsets. It changes `pin_in` only at falling edges, so the synchronizer latency counts exactly from the next rising edge.

// File: rtl/gpio32_pkg.sv
package gpio32_pkg;

    localparam int PORT_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int HALF_W   = 16;
    localparam int NBYTES   = PORT_W / BYTE_W;
    localparam int ADDR_W   = 3;
    localparam int SYNC_LEN = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic              legal;
        logic              pin_sel;
        logic              upper;
        logic [1:0]        lane;
        logic [NBYTES-1:0] be;
        acc_size_e         size;
    } acc_dec_t;

    // Byte lane 3 is bits 31..24: the lowest byte address maps to the most
    // significant byte of the register pair.
    function automatic acc_dec_t decode_access(logic [ADDR_W-1:0] addr, acc_size_e size);
        acc_dec_t d;
        d         = '0;
        d.size    = size;
        d.pin_sel = addr[2];
        d.upper   = ~addr[1];
        d.lane    = 2'd3 - addr[1:0];
        unique case (size)
            SZ_BYTE: begin
                d.legal = 1'b1;
                d.be    = NBYTES'(1) << d.lane;
            end
            SZ_HALF: begin
                d.legal = ~addr[0];
                d.be    = addr[1] ? 4'b0011 : 4'b1100;
            end
            SZ_WORD: begin
                d.legal = (addr[1:0] == 2'b00);
                d.be    = 4'b1111;
            end
            default: begin
                d.legal = 1'b0;
                d.be    = '0;
            end
        endcase
        if (!d.legal) d.be = '0;
        return d;
    endfunction

    function automatic logic [PORT_W-1:0] align_wdata(acc_size_e size, logic [PORT_W-1:0] w);
        unique case (size)
            SZ_BYTE: return {NBYTES{w[BYTE_W-1:0]}};
            SZ_HALF: return {2{w[HALF_W-1:0]}};
            default: return w;
        endcase
    endfunction

    function automatic logic [PORT_W-1:0] extract_rdata(acc_dec_t d, logic [PORT_W-1:0] raw);
        logic [PORT_W-1:0] sh;
        sh = raw >> {d.lane, 3'b000};
        if (!d.legal) return '0;
        unique case (d.size)
            SZ_BYTE: return {{(PORT_W-BYTE_W){1'b0}}, sh[BYTE_W-1:0]};
            SZ_HALF: return d.upper ? {{(PORT_W-HALF_W){1'b0}}, raw[PORT_W-1:HALF_W]}
                                    : {{(PORT_W-HALF_W){1'b0}}, raw[HALF_W-1:0]};
            default: return raw;
        endcase
    endfunction

endpackage

// File: rtl/gpio32_sync.sv
module gpio32_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio32_datareg.sv
module gpio32_datareg #(
    parameter int W  = 32,
    parameter int BW = 8,
    localparam int NB = W / BW
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          we,
    input  logic [NB-1:0] be,
    input  logic [W-1:0]  wval,
    output logic [W-1:0]  q
);
    for (genvar b = 0; b < NB; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (clr)             q[b*BW +: BW] <= '0;
            else if (we && be[b]) q[b*BW +: BW] <= wval[b*BW +: BW];
        end
    end
endmodule

// File: rtl/gpio32_rdpath.sv
module gpio32_rdpath
    import gpio32_pkg::*;
(
    input  acc_dec_t          dec,
    input  logic [PORT_W-1:0] dreg,
    input  logic [PORT_W-1:0] pins,
    input  logic [PORT_W-1:0] dir,
    output logic [PORT_W-1:0] rd_next
);
    logic [PORT_W-1:0] data_view;
    logic [PORT_W-1:0] raw;

    always_comb begin
        data_view = (dir & dreg) | (~dir & pins);
        raw       = dec.pin_sel ? pins : data_view;
        rd_next   = extract_rdata(dec, raw);
    end
endmodule

// File: rtl/gpio32_port.sv
module gpio32_port
    import gpio32_pkg::*;
(
    input  logic                 clk,
    input  logic                 por_rst,
    input  logic                 man_rst,
    input  logic                 bus_req,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [1:0]           bus_size,
    input  logic [PORT_W-1:0]    bus_wdata,
    output logic [PORT_W-1:0]    bus_rdata,
    input  logic [PORT_W-1:0]    pin_dir,
    input  logic [PORT_W-1:0]    pin_in,
    output logic [PORT_W-1:0]    pin_out,
    output logic [PORT_W-1:0]    pin_oe
);
    acc_dec_t          dec;
    logic              wr_en;
    logic [PORT_W-1:0] wval;
    logic [PORT_W-1:0] dreg;
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] rd_next;

    always_comb begin
        dec   = decode_access(bus_addr, acc_size_e'(bus_size));
        wr_en = bus_req & bus_wr & dec.legal & ~dec.pin_sel;
        wval  = align_wdata(dec.size, bus_wdata);
    end

    gpio32_datareg #(.W(PORT_W), .BW(BYTE_W)) u_dreg (
        .clk  (clk),
        .clr  (por_rst),
        .we   (wr_en),
        .be   (dec.be),
        .wval (wval),
        .q    (dreg)
    );

    gpio32_sync #(.W(PORT_W), .STAGES(SYNC_LEN)) u_sync (
        .clk (clk),
        .rst (por_rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio32_rdpath u_rd (
        .dec     (dec),
        .dreg    (dreg),
        .pins    (pin_sync),
        .dir     (pin_dir),
        .rd_next (rd_next)
    );

    always_ff @(posedge clk) begin
        if (por_rst || man_rst)      bus_rdata <= '0;
        else if (bus_req && !bus_wr) bus_rdata <= rd_next;
        else                         bus_rdata <= '0;
    end

    assign pin_out = dreg & pin_dir;
    assign pin_oe  = pin_dir;
endmodule

// File: rtl/gpio32_port_chk.sv
module gpio32_port_chk (
    input logic        clk,
    input logic        por_rst,
    input logic        man_rst,
    input logic        bus_req,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [1:0]  bus_size,
    input logic [31:0] bus_rdata,
    input logic [31:0] pin_dir,
    input logic [31:0] pin_out,
    input logic [31:0] pin_oe
);
    logic bad_acc;
    assign bad_acc = (bus_size == 2'd3) || (bus_size == 2'd1 && bus_addr[0]) ||
                     (bus_size == 2'd2 && bus_addr[1:0] != 2'b00);

    // R1
    por_clears_chk: assert property (@(posedge clk) disable iff (man_rst)
        por_rst |=> (pin_out == '0 && bus_rdata == '0));

    // R2
    manual_keeps_data_chk: assert property (@(posedge clk) disable iff (por_rst)
        (man_rst && !(bus_req && bus_wr)) ##1 $stable(pin_dir) |-> $stable(pin_out));

    // R2
    manual_clears_rd_chk: assert property (@(posedge clk) disable iff (por_rst)
        man_rst |=> bus_rdata == '0);

    // R6
    illegal_read_zero_chk: assert property (@(posedge clk) disable iff (por_rst)
        (bus_req && !bus_wr && bad_acc) |=> bus_rdata == '0);

    // R6
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (por_rst)
        (!bus_req || bus_wr) |=> bus_rdata == '0);

    // R7
    oe_follows_dir_chk: assert property (@(posedge clk) disable iff (por_rst)
        pin_oe == pin_dir);

    // R7
    input_not_driven_chk: assert property (@(posedge clk) disable iff (por_rst)
        (pin_out & ~pin_oe) == '0);

    // R10
    pinstate_write_chk: assert property (@(posedge clk) disable iff (por_rst)
        (bus_req && bus_wr && bus_addr[2]) ##1 $stable(pin_dir) |-> $stable(pin_out));
endmodule

bind gpio32_port gpio32_port_chk u_chk (.*);

// File: tb/gpio32_port_test.sv
module gpio32_port_test;
    logic        clk = 1'b0;
    logic        por_rst, man_rst, bus_req, bus_wr;
    logic [2:0]  bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata, bus_rdata, pin_dir, pin_in, pin_out, pin_oe;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    gpio32_port uut (
        .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .bus_req(bus_req),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_dir(pin_dir),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access; called just after a falling edge, returns just after the next one.
    task automatic acc(bit wr, logic [2:0] a, logic [1:0] sz, logic [31:0] w);
        bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = w;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [2:0] a, logic [1:0] sz, string req, logic [31:0] exp);
        acc(1'b0, a, sz, '0);
        chk(req, bus_rdata, exp);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        pin_dir = '1;
        acc(1'b1, 3'd0, 2'd2, 32'hA5A5_5A5A);
        chk("R7 pre-reset drive", pin_out, 32'hA5A5_5A5A);
        por_rst = 1'b1;
        idle(2);
        por_rst = 1'b0;
        chk("R1 pin_out cleared", pin_out, 32'h0);
        chk("R1 rdata cleared", bus_rdata, 32'h0);
        rd(3'd0, 2'd2, "R1 data reads zero", 32'h0);
    endtask

    task automatic t_word_half();
        pin_dir = '1;
        acc(1'b1, 3'd0, 2'd2, 32'h1234_5678);
        rd(3'd0, 2'd2, "R3 word read", 32'h1234_5678);
        chk("R7 output drive", pin_out, 32'h1234_5678);
        chk("R7 oe", pin_oe, 32'hFFFF_FFFF);
        rd(3'd0, 2'd1, "R4 high half", 32'h0000_1234);
        rd(3'd2, 2'd1, "R4 low half", 32'h0000_5678);
        acc(1'b1, 3'd2, 2'd1, 32'h0000_BEEF);
        chk("R4 low half write", pin_out, 32'h1234_BEEF);
    endtask

    task automatic t_byte();
        acc(1'b1, 3'd1, 2'd0, 32'h0000_0099);
        chk("R5 byte write offset 1", pin_out, 32'h1299_BEEF);
        rd(3'd3, 2'd0, "R5 byte read offset 3", 32'h0000_00EF);
        rd(3'd0, 2'd0, "R5 byte read offset 0", 32'h0000_0012);
    endtask

    task automatic t_illegal();
        acc(1'b1, 3'd2, 2'd2, 32'hFFFF_FFFF);
        acc(1'b1, 3'd1, 2'd1, 32'hFFFF_FFFF);
        acc(1'b1, 3'd0, 2'd3, 32'hFFFF_FFFF);
        chk("R6 illegal writes ignored", pin_out, 32'h1299_BEEF);
        rd(3'd2, 2'd2, "R6 word at 2", 32'h0);
        rd(3'd3, 2'd1, "R6 odd half", 32'h0);
        rd(3'd0, 2'd3, "R6 reserved size", 32'h0);
    endtask

    task automatic t_manual();
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = 3'd0; bus_size = 2'd2;
        man_rst = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_req = 1'b0;
        @(posedge clk); @(negedge clk);
        man_rst = 1'b0;
        chk("R2 rdata cleared", bus_rdata, 32'h0);
        chk("R2 data kept", pin_out, 32'h1299_BEEF);
        rd(3'd0, 2'd2, "R2 data readback", 32'h1299_BEEF);
    endtask

    task automatic t_input();
        pin_dir = 32'h0000_FFFF;
        pin_in  = 32'hCAFE_1111;
        idle(3);
        rd(3'd0, 2'd2, "R8 mixed read", 32'hCAFE_BEEF);
        chk("R7 oe mixed", pin_oe, 32'h0000_FFFF);
        chk("R7 input pins undriven", pin_out, 32'h0000_BEEF);
        acc(1'b1, 3'd0, 2'd2, 32'h5555_0000);
        chk("R9 input write no pin change", pin_out, 32'h0000_0000);
        rd(3'd0, 2'd2, "R8 read after write", 32'hCAFE_0000);
        pin_dir = '1;
        idle(1);
        chk("R9 stored value now driven", pin_out, 32'h5555_0000);
    endtask

    task automatic t_pinstate();
        pin_in = 32'h0F0F_1234;
        idle(3);
        rd(3'd4, 2'd2, "R10 pin word", 32'h0F0F_1234);
        rd(3'd6, 2'd1, "R10 pin low half", 32'h0000_1234);
        rd(3'd5, 2'd0, "R10 pin byte 5", 32'h0000_000F);
        acc(1'b1, 3'd4, 2'd2, 32'hFFFF_FFFF);
        chk("R10 pin write ignored", pin_out, 32'h5555_0000);
        rd(3'd0, 2'd2, "R10 data unaffected", 32'h5555_0000);
    endtask

    task automatic t_sync();
        pin_in = 32'hFFFF_FFFF;
        rd(3'd4, 2'd2, "R11 first edge old", 32'h0F0F_1234);
        rd(3'd4, 2'd2, "R11 second edge old", 32'h0F0F_1234);
        rd(3'd4, 2'd2, "R11 third edge new", 32'hFFFF_FFFF);
    endtask

    initial begin
        por_rst = 1'b1; man_rst = 1'b0; bus_req = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_size = '0; bus_wdata = '0; pin_dir = '0; pin_in = '0;
        idle(3);
        chk("R1 reset pin_out", pin_out, 32'h0);
        chk("R1 reset oe", pin_oe, 32'h0);
        chk("R1 reset rdata", bus_rdata, 32'h0);
        por_rst = 1'b0;
        idle(1);
        t_reset();
        t_word_half();
        t_byte();
        t_illegal();
        t_manual();
        t_input();
        t_pinstate();
        t_sync();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule